// File: doc/BRIEF.md
# Tagged Fully Associative Translation Cache

This block caches page-table entries for an address translation path. Every slot can hold any mapping, and each slot is tagged with a process identifier. Translations from several address spaces can therefore sit in the cache together. A lookup presents a virtual page number and a process identifier. In the same cycle the block answers hit or miss. On a hit it also returns the frame number and the access rights stored in that slot.

A miss is handled outside the block. An external agent walks the tables and offers the result on the refill port, which is a valid/ready stream. The block places a new mapping in the lowest-numbered empty slot. Only when every slot holds a live mapping does it overwrite a victim, chosen by a rotating pointer. A refill whose key is already cached rewrites that slot. Software can discard every mapping at once, or only the mappings of one process.

Back-pressure rules: a refill beat transfers on a rising edge where both `rf_valid` and `rf_ready` are high. `rf_ready` is low in any cycle where either flush input is high, and is otherwise high. While the beat waits, the producer keeps `rf_valid` high and its payload stable. The lookup port has no back-pressure: a request is accepted in every cycle and its answer is combinational.

Top module: `tagged_tlb`

## Requirements
- R1: While and after reset (`rst_n` low, asynchronous), every slot is empty, so any lookup returns `lk_hit`=0.
- R2: A lookup hits only when a live slot matches both `lk_vpn` and `lk_pid`. On a hit, `lk_pfn` and `lk_perm` return that slot's contents. `lk_perm` bit 0 is read, bit 1 is write and bit 2 is execute.
- R3: When `lk_valid` is high and no slot matches, `lk_miss` is 1 and `lk_pfn`/`lk_perm` are 0. When `lk_valid` is low, both `lk_hit` and `lk_miss` are 0.
- R4: An accepted refill with a new key goes to the lowest-indexed empty slot whenever at least one slot is empty. No live mapping is lost in that case.
- R5: When all slots are live, a refill with a new key overwrites the slot under a rotating pointer. The pointer is 0 after reset and steps by one (wrapping at the slot count) after each such eviction only.
- R6: An accepted refill whose page number and process identifier are both already cached rewrites that slot's frame and rights in place. It creates no second copy, evicts nothing and leaves the rotating pointer unmoved.
- R7: A cycle with `flush_all` high empties every slot at that clock edge.
- R8: A cycle with `flush_pid_en` high (and `flush_all` low) empties exactly the slots whose process identifier equals `flush_pid`. All other slots are untouched.
- R9: `rf_ready` is 0 in any cycle with a flush request and 1 otherwise. A refill offered during a flush is held and is written after the flush.
- R10: A lookup in the same cycle as an accepted refill sees the contents from before the refill. The new mapping is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 8 | Lookup process identifier |
| lk_hit | output | 1 | Lookup found a live matching slot |
| lk_miss | output | 1 | Lookup requested and nothing matched |
| lk_pfn | output | 20 | Frame number on hit, else 0 |
| lk_perm | output | 3 | Rights on hit {X,W,R}, else 0 |
| rf_valid | input | 1 | Refill beat offered |
| rf_ready | output | 1 | Refill beat can be taken this cycle |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_pid | input | 8 | Refill process identifier |
| rf_pfn | input | 20 | Refill frame number |
| rf_perm | input | 3 | Refill rights {X,W,R} |
| flush_all | input | 1 | Empty every slot |
| flush_pid_en | input | 1 | Empty slots of one process |
| flush_pid | input | 8 | Process identifier to flush |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a refill and a lookup of the same key: the bench offers both together and expects a miss in that cycle and a hit one cycle later. The second pair is a flush and a refill: the bench raises a flush while a refill beat is offered, expects `rf_ready` low, holds the beat, and then checks that the mapping survives because it was written after the flush. A behavioural model runs on every clock and judges both cases, as well as a long random mix in which lookups, refills and both kinds of flush overlap freely.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Position of each access right inside the rights field.
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  // Where an accepted refill lands.
  typedef enum logic [1:0] {
    SLOT_SAME   = 2'd0,  // key already cached: rewrite in place
    SLOT_EMPTY  = 2'd1,  // lowest empty slot
    SLOT_VICTIM = 2'd2   // all live: rotating victim
  } slot_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 32,
  parameter int VPN_W = 20,
  parameter int PID_W = 8
) (
  input  logic [N-1:0]            live,
  input  logic [N-1:0][VPN_W-1:0] slot_vpn,
  input  logic [N-1:0][PID_W-1:0] slot_pid,
  input  logic [VPN_W-1:0]        key_vpn,
  input  logic [PID_W-1:0]        key_pid,
  output logic [N-1:0]            pid_eq,
  output logic [N-1:0]            full_eq
);
  // One comparator per slot.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign pid_eq[g]  = live[g] && (slot_pid[g] == key_pid);
    assign full_eq[g] = pid_eq[g] && (slot_vpn[g] == key_vpn);
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick
  import tlb_pkg::*;
#(
  parameter int N     = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     live,
  input  logic [N-1:0]     same_key,
  input  logic             accept,
  output logic [IDX_W-1:0] pick_idx,
  output slot_kind_e       pick_kind
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] empty_idx;

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < N; i++)
      if (same_key[i]) same_idx = IDX_W'(i);
    empty_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!live[i]) empty_idx = IDX_W'(i);
  end

  always_comb begin
    if (|same_key) begin
      pick_kind = SLOT_SAME;
      pick_idx  = same_idx;
    end else if (!(&live)) begin
      pick_kind = SLOT_EMPTY;
      pick_idx  = empty_idx;
    end else begin
      pick_kind = SLOT_VICTIM;
      pick_idx  = rr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_q <= '0;
    else if (accept && pick_kind == SLOT_VICTIM)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  // Pointer moves only on an eviction (R5, R6).
  p_rr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && pick_kind == SLOT_VICTIM) |=> $stable(rr_q));
  // A victim is taken only when no slot is empty (R4).
  p_victim_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pick_kind == SLOT_VICTIM) |-> (&live));
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N      = 32,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int PID_W  = 8,
  parameter int PERM_W = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_all,
  input  logic                     clr_some,
  input  logic [N-1:0]             clr_mask,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [PID_W-1:0]         wr_pid,
  input  logic [PFN_W-1:0]         wr_pfn,
  input  logic [PERM_W-1:0]        wr_perm,
  output logic [N-1:0]             live,
  output logic [N-1:0][VPN_W-1:0]  slot_vpn,
  output logic [N-1:0][PID_W-1:0]  slot_pid,
  output logic [N-1:0][PFN_W-1:0]  slot_pfn,
  output logic [N-1:0][PERM_W-1:0] slot_perm
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
    end else if (clr_all) begin
      live <= '0;
    end else if (clr_some) begin
      live <= live & ~clr_mask;
    end else if (wr_en) begin
      live[wr_idx] <= 1'b1;
    end
  end

  // Payload needs no reset; it is qualified by the live bits.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_vpn[wr_idx]  <= wr_vpn;
      slot_pid[wr_idx]  <= wr_pid;
      slot_pfn[wr_idx]  <= wr_pfn;
      slot_perm[wr_idx] <= wr_perm;
    end
  end

  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (live == '0));
  p_flush_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_some && !clr_all) |=> ((live & $past(clr_mask)) == '0));
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tlb_pkg::*;
#(
  parameter int N      = 32,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int PID_W  = 8,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PID_W-1:0]  lk_pid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              rf_valid,
  output logic              rf_ready,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PID_W-1:0]  rf_pid,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [PERM_W-1:0] rf_perm,
  input  logic              flush_all,
  input  logic              flush_pid_en,
  input  logic [PID_W-1:0]  flush_pid
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]             live;
  logic [N-1:0][VPN_W-1:0]  slot_vpn;
  logic [N-1:0][PID_W-1:0]  slot_pid;
  logic [N-1:0][PFN_W-1:0]  slot_pfn;
  logic [N-1:0][PERM_W-1:0] slot_perm;

  logic [N-1:0] lk_match, lk_pid_unused;
  logic [N-1:0] rf_match, rf_pid_unused;
  logic [N-1:0] fl_pid_match, fl_full_unused;
  logic         accept;
  logic [IDX_W-1:0] pick_idx;
  slot_kind_e       pick_kind;

  assign rf_ready = !(flush_all || flush_pid_en);
  assign accept   = rf_valid && rf_ready;

  tlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_match (
    .live(live), .slot_vpn(slot_vpn), .slot_pid(slot_pid),
    .key_vpn(lk_vpn), .key_pid(lk_pid),
    .pid_eq(lk_pid_unused), .full_eq(lk_match));

  tlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_rf_match (
    .live(live), .slot_vpn(slot_vpn), .slot_pid(slot_pid),
    .key_vpn(rf_vpn), .key_pid(rf_pid),
    .pid_eq(rf_pid_unused), .full_eq(rf_match));

  tlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_fl_match (
    .live(live), .slot_vpn(slot_vpn), .slot_pid(slot_pid),
    .key_vpn(rf_vpn), .key_pid(flush_pid),
    .pid_eq(fl_pid_match), .full_eq(fl_full_unused));

  tlb_pick #(.N(N)) u_pick (
    .clk(clk), .rst_n(rst_n), .live(live), .same_key(rf_match),
    .accept(accept), .pick_idx(pick_idx), .pick_kind(pick_kind));

  tlb_store #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W),
              .PERM_W(PERM_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .clr_all(flush_all), .clr_some(flush_pid_en), .clr_mask(fl_pid_match),
    .wr_en(accept), .wr_idx(pick_idx),
    .wr_vpn(rf_vpn), .wr_pid(rf_pid), .wr_pfn(rf_pfn), .wr_perm(rf_perm),
    .live(live), .slot_vpn(slot_vpn), .slot_pid(slot_pid),
    .slot_pfn(slot_pfn), .slot_perm(slot_perm));

  // Lookup read-out: OR of the (at most one) matching slot.
  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_valid && lk_match[i]) begin
        lk_pfn  = lk_pfn  | slot_pfn[i];
        lk_perm = lk_perm | slot_perm[i];
      end
    end
  end

  assign lk_hit  = lk_valid && (|lk_match);
  assign lk_miss = lk_valid && !(|lk_match);

  // No key is ever cached twice (R6).
  p_single_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  // An accepted refill is live in its slot at the next cycle (R10).
  p_refill_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> live[$past(pick_idx)]);
  // Filling an empty slot grows the live count by exactly one (R4).
  p_fill_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pick_kind == SLOT_EMPTY) |=>
      ($countones(live) == $countones($past(live)) + 1));
  // Hit and miss are never high together (R3).
  p_hit_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));
endmodule

// File: tb/tagged_tlb_tb.sv
module tagged_tlb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_hit, lk_miss;
  logic [19:0] lk_pfn;
  logic [2:0]  lk_perm;
  logic        rf_valid = 1'b0;
  logic        rf_ready;
  logic [19:0] rf_vpn = '0;
  logic [7:0]  rf_pid = '0;
  logic [19:0] rf_pfn = '0;
  logic [2:0]  rf_perm = '0;
  logic        flush_all = 1'b0;
  logic        flush_pid_en = 1'b0;
  logic [7:0]  flush_pid = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_tlb u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_vpn(rf_vpn),
    .rf_pid(rf_pid), .rf_pfn(rf_pfn), .rf_perm(rf_perm),
    .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid));

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Behavioural reference model.
  bit m_v[N];
  int m_vpn[N], m_pid[N], m_pfn[N], m_perm[N];
  int m_rr = 0;

  function automatic int m_find(int vpn, int pid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      m_rr = 0;
    end else if (flush_all) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else if (flush_pid_en) begin
      for (int i = 0; i < N; i++)
        if (m_pid[i] == int'(flush_pid)) m_v[i] = 1'b0;
    end else if (rf_valid) begin
      int slot;
      slot = m_find(int'(rf_vpn), int'(rf_pid));
      if (slot < 0) begin
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      end
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[slot] = 1'b1;
      m_vpn[slot] = int'(rf_vpn);
      m_pid[slot] = int'(rf_pid);
      m_pfn[slot] = int'(rf_pfn);
      m_perm[slot] = int'(rf_perm);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare against the model every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      int s, eh, em, ep, er;
      s  = m_find(int'(lk_vpn), int'(lk_pid));
      eh = (lk_valid && s >= 0) ? 1 : 0;
      em = (lk_valid && s < 0) ? 1 : 0;
      ep = eh ? m_pfn[s] : 0;
      er = eh ? m_perm[s] : 0;
      check(int'(lk_hit) == eh, cur_req, "model hit", int'(lk_hit), eh);
      check(int'(lk_miss) == em, "R3", "model miss", int'(lk_miss), em);
      check(int'(lk_pfn) == ep, cur_req, "model pfn", int'(lk_pfn), ep);
      check(int'(lk_perm) == er, cur_req, "model perm", int'(lk_perm), er);
      check(int'(rf_ready) == ((flush_all || flush_pid_en) ? 0 : 1), "R9",
            "model ready", int'(rf_ready), (flush_all || flush_pid_en) ? 0 : 1);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    step();
    rf_valid = 1'b0; lk_valid = 1'b0; flush_all = 1'b0; flush_pid_en = 1'b0;
  endtask

  task automatic refill(int vpn, int pid, int pfn, int perm);
    step();
    lk_valid = 1'b0; flush_all = 1'b0; flush_pid_en = 1'b0;
    rf_valid = 1'b1; rf_vpn = 20'(vpn); rf_pid = 8'(pid);
    rf_pfn = 20'(pfn); rf_perm = 3'(perm);
  endtask

  // Directed lookup with a literal expectation.
  task automatic probe(int vpn, int pid, int eh, int ep, string req);
    step();
    rf_valid = 1'b0; flush_all = 1'b0; flush_pid_en = 1'b0;
    lk_valid = 1'b1; lk_vpn = 20'(vpn); lk_pid = 8'(pid);
    #2;
    check(int'(lk_hit) == eh, req, "hit", int'(lk_hit), eh);
    if (eh == 1) check(int'(lk_pfn) == ep, req, "pfn", int'(lk_pfn), ep);
    else check(int'(lk_pfn) == 0, req, "pfn on miss", int'(lk_pfn), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: lookups miss during and right after reset.
    cur_req = "R1";
    step(); lk_valid = 1'b1; lk_vpn = 20'd5; lk_pid = 8'd1; #2;
    check(int'(lk_hit) == 0, "R1", "hit in reset", int'(lk_hit), 0);
    step(); rst_n = 1'b1;
    probe(5, 1, 0, 0, "R1");

    // R2/R3: basic hits, tag mismatch, lookup idle.
    cur_req = "R2";
    refill(10, 1, 'h111, 3'b001);
    refill(11, 2, 'h222, 3'b110);
    idle();
    probe(10, 1, 1, 'h111, "R2");
    step(); #2;
    check(int'(lk_perm) == 1, "R2", "read right", int'(lk_perm), 1);
    probe(11, 2, 1, 'h222, "R2");
    probe(10, 2, 0, 0, "R2");
    cur_req = "R3";
    probe(99, 1, 0, 0, "R3");
    check(int'(lk_miss) == 1, "R3", "miss flag", int'(lk_miss), 1);
    idle(); #2;
    check(int'(lk_miss) == 0, "R3", "miss without request", int'(lk_miss), 0);

    // R7: global flush.
    cur_req = "R7";
    step(); flush_all = 1'b1;
    idle();
    probe(10, 1, 0, 0, "R7");
    probe(11, 2, 0, 0, "R7");

    // R4/R8: free-slot reuse after per-process flush.
    cur_req = "R4";
    refill(100, 1, 'h100, 1);
    refill(101, 2, 'h101, 1);
    refill(102, 1, 'h102, 1);
    step(); rf_valid = 1'b0; flush_pid_en = 1'b1; flush_pid = 8'd2;
    idle();
    cur_req = "R8";
    probe(101, 2, 0, 0, "R8");
    probe(100, 1, 1, 'h100, "R8");
    probe(102, 1, 1, 'h102, "R8");
    cur_req = "R4";
    refill(150, 1, 'h150, 2);
    for (int v = 103; v < 132; v++) refill(v, 1, v, 4);
    idle();
    probe(131, 1, 1, 131, "R4");
    probe(100, 1, 1, 'h100, "R4");

    // R5: rotating victims (slots 0,1,2 hold 100,150,102).
    cur_req = "R5";
    refill(200, 1, 'h200, 1);
    idle();
    probe(100, 1, 0, 0, "R5");
    probe(150, 1, 1, 'h150, "R5");
    refill(201, 1, 'h201, 1);
    idle();
    probe(150, 1, 0, 0, "R5");
    probe(102, 1, 1, 'h102, "R5");

    // R6: in-place rewrite while full; pointer stays at slot 2.
    cur_req = "R6";
    refill(120, 1, 'hABC, 7);
    idle();
    probe(120, 1, 1, 'hABC, "R6");
    probe(102, 1, 1, 'h102, "R6");
    refill(202, 1, 'h202, 1);
    idle();
    probe(102, 1, 0, 0, "R6");
    probe(103, 1, 1, 103, "R6");

    // R10: lookup and refill of the same key in one cycle.
    cur_req = "R10";
    step(); flush_all = 1'b1;
    step(); flush_all = 1'b0;
    rf_valid = 1'b1; rf_vpn = 20'd300; rf_pid = 8'd3; rf_pfn = 20'h300; rf_perm = 3'd5;
    lk_valid = 1'b1; lk_vpn = 20'd300; lk_pid = 8'd3; #2;
    check(int'(lk_hit) == 0, "R10", "same-cycle hit", int'(lk_hit), 0);
    step(); rf_valid = 1'b0; #2;
    check(int'(lk_hit) == 1, "R10", "next-cycle hit", int'(lk_hit), 1);
    check(int'(lk_pfn) == 'h300, "R10", "next-cycle pfn", int'(lk_pfn), 'h300);

    // R9: refill held through a flush.
    cur_req = "R9";
    step(); lk_valid = 1'b0;
    flush_all = 1'b1;
    rf_valid = 1'b1; rf_vpn = 20'd400; rf_pid = 8'd4; rf_pfn = 20'h400; rf_perm = 3'd3;
    #2;
    check(int'(rf_ready) == 0, "R9", "ready during flush", int'(rf_ready), 0);
    step(); flush_all = 1'b0; #2;
    check(int'(rf_ready) == 1, "R9", "ready after flush", int'(rf_ready), 1);
    idle();
    probe(400, 4, 1, 'h400, "R9");
    probe(300, 3, 0, 0, "R9");

    // Random mix, judged by the model.
    cur_req = "R2";
    for (int k = 0; k < 3000; k++) begin
      int r;
      step();
      r = int'($urandom_range(0, 99));
      flush_all = (r < 2);
      flush_pid_en = (r >= 2 && r < 6);
      flush_pid = 8'($urandom_range(0, 2));
      rf_valid = (r >= 6 && r < 60);
      rf_vpn = 20'($urandom_range(0, 40));
      rf_pid = 8'($urandom_range(0, 2));
      rf_pfn = 20'($urandom_range(0, 1048575));
      rf_perm = 3'($urandom_range(0, 7));
      lk_valid = ($urandom_range(0, 3) != 0);
      lk_vpn = 20'($urandom_range(0, 40));
      lk_pid = 8'($urandom_range(0, 2));
    end
    idle();
    step();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule